// File: doc/BRIEF.md
# Width-Converting DMA Byte FIFO

This block is a sixteen-byte buffer that joins a 16-bit memory-transfer port to an 8-bit byte stream port. A word written from the memory side is split into two bytes, low lane first. Bytes pushed from the byte side are paired into words, with the first byte in the low lane. A request line asks the memory-side engine for a burst once eight bytes are ready to be read, or eight byte slots are free, depending on the transfer direction.

Each memory-side byte lane has a parity bit. One mode generates parity on words leaving the block and checks it on words entering. The other mode stores the incoming parity bits and returns them unchanged. A transfer toward memory that starts on an odd byte can have a host-loaded alignment byte placed in the low lane of its first word. A host byte port can push or pop single bytes, for example to drain what is left after an aborted transfer. A synchronous flush empties the buffer in one clock. The occupancy count and sticky error flags are always visible.

Top module: `dma_byte_fifo`

## Requirements
- R1: The buffer holds up to 16 bytes. `count` shows the bytes stored (0 to 16). `empty` is high when it is 0 and `full` is high when it is 16. After reset the buffer is empty and every flag is low.
- R2: An accepted word write stores `dma_wdata[7:0]` ahead of `dma_wdata[15:8]` and raises `count` by 2. The byte side therefore pops the low byte before the high byte. `byte_rdata` always shows the oldest stored byte.
- R3: An accepted word read (not aligned) returns the oldest byte in `dma_rdata[7:0]` and the next byte in `dma_rdata[15:8]`, and lowers `count` by 2. `dma_rdata` and `dma_rpar` show the word that the next read would take.
- R4: A word write is accepted only when at least 2 bytes are free, and a byte push only when the buffer is not full. A refused access changes nothing and sets the sticky `ovf_flag`.
- R5: A word read is accepted only when at least 2 bytes are stored (1 byte when alignment is armed), and a byte pop only when the buffer is not empty. A refused access changes nothing and sets the sticky `udf_flag`.
- R6: With `par_mode`=0, parity is odd: the parity bit makes the number of ones across the byte and the bit odd. `dma_rpar[i]` is generated from lane i of `dma_rdata`. An accepted word write whose `dma_wpar` bits disagree with odd parity sets the sticky `perr_flag`.
- R7: With `par_mode`=1, `dma_wpar` bits are stored with their bytes and returned unchanged on `dma_rpar` when those bytes are read, and `perr_flag` is never set. Bytes pushed from the byte side are stored with generated odd parity.
- R8: `align_wr` loads `align_data` and arms alignment. While armed, the next accepted word read returns the alignment byte in the low lane (its parity always generated) and the oldest stored byte in the high lane. That read consumes one byte and disarms alignment. An `align_wr` in the same cycle arms it again.
- R9: `dreq` is high when `xfer_dir`=0 (toward memory) and `count` is at least 8, or when `xfer_dir`=1 (from memory) and at least 8 bytes are free.
- R10: `flush` empties the buffer, returns both byte pointers to slot 0 and disarms alignment, all in one clock. It leaves the error flags unchanged.
- R11: `err_clr` clears `ovf_flag`, `udf_flag` and `perr_flag`. An error detected in the same cycle still sets its flag.
- R12: Only one access is performed per cycle, taken in this order: `flush`, `dma_wr`, `dma_rd`, `sc_push`, `sc_pop`, `host_wr`, `host_rd`. Lower-priority requests in that cycle are ignored and set no flag.
- R13: The host port pushes `host_wdata` with `host_wr` and pops the oldest byte with `host_rd`, with the same storage, limits and flags as the byte-stream port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty request |
| err_clr | input | 1 | Clears the sticky error flags |
| par_mode | input | 1 | 0 = generate/check parity, 1 = pass parity through |
| xfer_dir | input | 1 | 0 = toward memory, 1 = from memory (request threshold) |
| align_wr | input | 1 | Loads the alignment byte and arms alignment |
| align_data | input | 8 | Alignment byte |
| dma_wr | input | 1 | Word write request |
| dma_wdata | input | 16 | Word write data |
| dma_wpar | input | 2 | Word write parity, one bit per lane |
| dma_rd | input | 1 | Word read request |
| dma_rdata | output | 16 | Word the next read takes |
| dma_rpar | output | 2 | Parity of dma_rdata lanes |
| dreq | output | 1 | Burst request |
| sc_push | input | 1 | Byte-stream push |
| sc_wdata | input | 8 | Byte-stream push data |
| sc_pop | input | 1 | Byte-stream pop |
| host_wr | input | 1 | Host byte push |
| host_wdata | input | 8 | Host byte push data |
| host_rd | input | 1 | Host byte pop |
| byte_rdata | output | 8 | Oldest stored byte |
| count | output | 5 | Bytes stored |
| full | output | 1 | 16 bytes stored |
| empty | output | 1 | No byte stored |
| ovf_flag | output | 1 | Sticky refused-write flag |
| udf_flag | output | 1 | Sticky refused-read flag |
| perr_flag | output | 1 | Sticky parity mismatch flag |

## Verification
The hardest states to reach are the odd occupancies at the word boundaries. One is a word write refused with exactly 15 bytes stored. The other is an aligned word read with only one byte present, where an unaligned read would be refused. Directed sequences build these states from mixed word writes and single-byte pushes and pops. A seeded random mix then covers priority collisions, flushes in the middle of traffic and parity-mode changes while data is buffered. A queue model in the bench predicts every output each cycle.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH,
    OP_WWR,
    OP_WRD,
    OP_SPUSH,
    OP_SPOP,
    OP_HPUSH,
    OP_HPOP
  } op_e;

  // odd parity: the returned bit makes the total count of ones odd
  function automatic logic odd_parity(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/dbf_arbiter.sv
module dbf_arbiter
  import dbf_pkg::*;
(
  input  logic flush,
  input  logic dma_wr,
  input  logic dma_rd,
  input  logic sc_push,
  input  logic sc_pop,
  input  logic host_wr,
  input  logic host_rd,
  output op_e  op
);

  // fixed priority, one access per cycle
  always_comb begin
    if (flush)        op = OP_FLUSH;
    else if (dma_wr)  op = OP_WWR;
    else if (dma_rd)  op = OP_WRD;
    else if (sc_push) op = OP_SPUSH;
    else if (sc_pop)  op = OP_SPOP;
    else if (host_wr) op = OP_HPUSH;
    else if (host_rd) op = OP_HPOP;
    else              op = OP_IDLE;
  end

endmodule

// File: rtl/dbf_ctl.sv
module dbf_ctl
  import dbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          err_clr,
  input  logic          par_mode,
  input  logic [1:0]    par_bad,
  input  logic          align_wr,
  input  logic [7:0]    align_data,
  output logic          we_lo,
  output logic          we_hi,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          armed,
  output logic [7:0]    align_q,
  output logic          ovf,
  output logic          udf,
  output logic          perr
);

  logic [CW-1:0] free_slots;
  logic [CW-1:0] count_nx;
  logic [AW-1:0] wptr_nx, rptr_nx;
  logic          armed_nx;
  logic          set_ovf, set_udf, set_perr;
  logic          ovf_nx, udf_nx, perr_nx;

  always_comb begin
    free_slots = CW'(DEPTH) - count;
    count_nx   = count;
    wptr_nx    = wptr;
    rptr_nx    = rptr;
    armed_nx   = armed;
    we_lo      = 1'b0;
    we_hi      = 1'b0;
    set_ovf    = 1'b0;
    set_udf    = 1'b0;
    set_perr   = 1'b0;
    case (op)
      OP_FLUSH: begin
        count_nx = '0;
        wptr_nx  = '0;
        rptr_nx  = '0;
      end
      OP_WWR: begin
        if (free_slots >= CW'(2)) begin
          we_lo    = 1'b1;
          we_hi    = 1'b1;
          wptr_nx  = wptr + AW'(2);
          count_nx = count + CW'(2);
          set_perr = !par_mode && (par_bad != 2'b00);
        end else begin
          set_ovf = 1'b1;
        end
      end
      OP_WRD: begin
        if (armed && count != '0) begin
          rptr_nx  = rptr + AW'(1);
          count_nx = count - CW'(1);
          armed_nx = 1'b0;
        end else if (!armed && count >= CW'(2)) begin
          rptr_nx  = rptr + AW'(2);
          count_nx = count - CW'(2);
        end else begin
          set_udf = 1'b1;
        end
      end
      OP_SPUSH, OP_HPUSH: begin
        if (count < CW'(DEPTH)) begin
          we_lo    = 1'b1;
          wptr_nx  = wptr + AW'(1);
          count_nx = count + CW'(1);
        end else begin
          set_ovf = 1'b1;
        end
      end
      OP_SPOP, OP_HPOP: begin
        if (count != '0) begin
          rptr_nx  = rptr + AW'(1);
          count_nx = count - CW'(1);
        end else begin
          set_udf = 1'b1;
        end
      end
      default: ;
    endcase
    if (op == OP_FLUSH)  armed_nx = 1'b0;
    else if (align_wr)   armed_nx = 1'b1;
    ovf_nx  = (ovf  & ~err_clr) | set_ovf;
    udf_nx  = (udf  & ~err_clr) | set_udf;
    perr_nx = (perr & ~err_clr) | set_perr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      wptr    <= '0;
      rptr    <= '0;
      armed   <= 1'b0;
      align_q <= '0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
      perr    <= 1'b0;
    end else begin
      count <= count_nx;
      wptr  <= wptr_nx;
      rptr  <= rptr_nx;
      armed <= armed_nx;
      ovf   <= ovf_nx;
      udf   <= udf_nx;
      perr  <= perr_nx;
      if (align_wr) align_q <= align_data;
    end
  end

endmodule

// File: rtl/dbf_store.sv
module dbf_store #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [AW-1:0] wptr,
  input  logic [8:0]    d_lo,
  input  logic [8:0]    d_hi,
  input  logic [AW-1:0] rptr,
  output logic [8:0]    head,
  output logic [8:0]    next
);

  // each slot holds {parity, byte}; storage carries no reset
  logic [8:0]    slot [DEPTH];
  logic [AW-1:0] wptr_p1, rptr_p1;

  assign wptr_p1 = wptr + AW'(1);
  assign rptr_p1 = rptr + AW'(1);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_lo && wptr == AW'(i))         slot[i] <= d_lo;
      else if (we_hi && wptr_p1 == AW'(i)) slot[i] <= d_hi;
    end
  end

  assign head = slot[rptr];
  assign next = slot[rptr_p1];

endmodule

// File: rtl/dbf_lanes.sv
module dbf_lanes
  import dbf_pkg::*;
(
  input  logic [8:0]  head,
  input  logic [8:0]  next,
  input  logic [7:0]  align_q,
  input  logic        armed,
  input  logic        par_mode,
  output logic [15:0] rdata,
  output logic [1:0]  rpar
);

  logic [8:0] lane [2];

  assign lane[0] = armed ? {odd_parity(align_q), align_q} : head;
  assign lane[1] = armed ? head : next;

  generate
    for (genvar l = 0; l < 2; l++) begin : g_lane
      assign rdata[8*l +: 8] = lane[l][7:0];
      assign rpar[l]         = par_mode ? lane[l][8] : odd_parity(lane[l][7:0]);
    end
  endgenerate

endmodule

// File: rtl/dma_byte_fifo.sv
module dma_byte_fifo
  import dbf_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int BURST = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          err_clr,
  input  logic          par_mode,
  input  logic          xfer_dir,
  input  logic          align_wr,
  input  logic [7:0]    align_data,
  input  logic          dma_wr,
  input  logic [15:0]   dma_wdata,
  input  logic [1:0]    dma_wpar,
  input  logic          dma_rd,
  output logic [15:0]   dma_rdata,
  output logic [1:0]    dma_rpar,
  output logic          dreq,
  input  logic          sc_push,
  input  logic [7:0]    sc_wdata,
  input  logic          sc_pop,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  output logic [7:0]    byte_rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          perr_flag
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  op_e           op;
  logic          we_lo, we_hi, armed;
  logic [AW-1:0] wptr, rptr;
  logic [7:0]    align_q, push_byte;
  logic [8:0]    d_lo, d_hi, head, next;
  logic [1:0]    par_exp, par_bad;

  dbf_arbiter i_arb (
    .flush   (flush),
    .dma_wr  (dma_wr),
    .dma_rd  (dma_rd),
    .sc_push (sc_push),
    .sc_pop  (sc_pop),
    .host_wr (host_wr),
    .host_rd (host_rd),
    .op      (op)
  );

  // incoming byte and parity selection
  assign push_byte  = (op == OP_HPUSH) ? host_wdata : sc_wdata;
  assign par_exp[0] = odd_parity(dma_wdata[7:0]);
  assign par_exp[1] = odd_parity(dma_wdata[15:8]);
  assign par_bad    = dma_wpar ^ par_exp;

  always_comb begin
    if (op == OP_WWR) begin
      d_lo = {par_mode ? dma_wpar[0] : par_exp[0], dma_wdata[7:0]};
    end else begin
      d_lo = {odd_parity(push_byte), push_byte};
    end
    d_hi = {par_mode ? dma_wpar[1] : par_exp[1], dma_wdata[15:8]};
  end

  dbf_ctl #(.DEPTH(DEPTH)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_q),
    .op         (op),
    .err_clr    (err_clr),
    .par_mode   (par_mode),
    .par_bad    (par_bad),
    .align_wr   (align_wr),
    .align_data (align_data),
    .we_lo      (we_lo),
    .we_hi      (we_hi),
    .wptr       (wptr),
    .rptr       (rptr),
    .count      (count),
    .armed      (armed),
    .align_q    (align_q),
    .ovf        (ovf_flag),
    .udf        (udf_flag),
    .perr       (perr_flag)
  );

  dbf_store #(.DEPTH(DEPTH)) i_store (
    .clk   (clk),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .wptr  (wptr),
    .d_lo  (d_lo),
    .d_hi  (d_hi),
    .rptr  (rptr),
    .head  (head),
    .next  (next)
  );

  dbf_lanes i_lanes (
    .head     (head),
    .next     (next),
    .align_q  (align_q),
    .armed    (armed),
    .par_mode (par_mode),
    .rdata    (dma_rdata),
    .rpar     (dma_rpar)
  );

  assign byte_rdata = head[7:0];
  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign dreq       = xfer_dir ? ((CW'(DEPTH) - count) >= CW'(BURST))
                               : (count >= CW'(BURST));

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          err_clr,
  input logic          dma_wr,
  input logic          dma_rd,
  input logic          sc_push,
  input logic          sc_pop,
  input logic [CW-1:0] count,
  input logic          empty,
  input logic          ovf_flag,
  input logic          udf_flag,
  input logic          perr_flag
);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_word_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !flush && count <= CW'(DEPTH - 2)) |=> count == $past(count) + CW'(2));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !flush && count > CW'(DEPTH - 2)) |=> (ovf_flag && count == $past(count)));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_pop && !flush && !dma_wr && !dma_rd && !sc_push && empty) |=> (udf_flag && empty));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !err_clr) |=> perr_flag);

endmodule

bind dma_byte_fifo dbf_checker #(.DEPTH(DEPTH)) i_dbf_checker (
  .clk       (clk),
  .rst_n     (rst_q),
  .flush     (flush),
  .err_clr   (err_clr),
  .dma_wr    (dma_wr),
  .dma_rd    (dma_rd),
  .sc_push   (sc_push),
  .sc_pop    (sc_pop),
  .count     (count),
  .empty     (empty),
  .ovf_flag  (ovf_flag),
  .udf_flag  (udf_flag),
  .perr_flag (perr_flag)
);

// File: tb/test_dma_byte_fifo.sv
module test_dma_byte_fifo;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, flush, err_clr, par_mode, xfer_dir, align_wr;
  logic [7:0]  align_data, sc_wdata, host_wdata, byte_rdata;
  logic        dma_wr, dma_rd, sc_push, sc_pop, host_wr, host_rd;
  logic [15:0] dma_wdata, dma_rdata;
  logic [1:0]  dma_wpar, dma_rpar;
  logic        dreq, full, empty, ovf_flag, udf_flag, perr_flag;
  logic [4:0]  count;

  dma_byte_fifo i_dma_byte_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .err_clr(err_clr),
    .par_mode(par_mode), .xfer_dir(xfer_dir), .align_wr(align_wr),
    .align_data(align_data), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .dma_wpar(dma_wpar), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .dma_rpar(dma_rpar), .dreq(dreq), .sc_push(sc_push), .sc_wdata(sc_wdata),
    .sc_pop(sc_pop), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .byte_rdata(byte_rdata), .count(count), .full(full),
    .empty(empty), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .perr_flag(perr_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [8:0] q[$];
  bit         m_armed, m_ovf, m_udf, m_perr;
  logic [7:0] m_align;

  function automatic logic opar(input logic [7:0] b);
    return ~^b;
  endfunction

  function automatic logic lane_par(input logic [8:0] e, input logic pm);
    return pm ? e[8] : opar(e[7:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; err_clr = 0; align_wr = 0; dma_wr = 0; dma_rd = 0;
    sc_push = 0; sc_pop = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic model_step();
    int  sz;
    bit  so, su, sp;
    sz = q.size();
    so = 0; su = 0; sp = 0;
    if (flush) begin
      q.delete();
      m_armed = 0;
    end else if (dma_wr) begin
      if (16 - sz >= 2) begin
        q.push_back({par_mode ? dma_wpar[0] : opar(dma_wdata[7:0]), dma_wdata[7:0]});
        q.push_back({par_mode ? dma_wpar[1] : opar(dma_wdata[15:8]), dma_wdata[15:8]});
        if (!par_mode && (dma_wpar[0] != opar(dma_wdata[7:0]) ||
                          dma_wpar[1] != opar(dma_wdata[15:8]))) sp = 1;
      end else so = 1;
    end else if (dma_rd) begin
      if (m_armed && sz >= 1) begin
        void'(q.pop_front());
        m_armed = 0;
      end else if (!m_armed && sz >= 2) begin
        void'(q.pop_front());
        void'(q.pop_front());
      end else su = 1;
    end else if (sc_push) begin
      if (sz < 16) q.push_back({opar(sc_wdata), sc_wdata}); else so = 1;
    end else if (sc_pop) begin
      if (sz > 0) void'(q.pop_front()); else su = 1;
    end else if (host_wr) begin
      if (sz < 16) q.push_back({opar(host_wdata), host_wdata}); else so = 1;
    end else if (host_rd) begin
      if (sz > 0) void'(q.pop_front()); else su = 1;
    end
    if (!flush && align_wr) m_armed = 1;
    if (align_wr) m_align = align_data;
    m_ovf  = (m_ovf  && !err_clr) || so;
    m_udf  = (m_udf  && !err_clr) || su;
    m_perr = (m_perr && !err_clr) || sp;
  endtask

  task automatic compare_all();
    int sz;
    logic [15:0] ew;
    logic [1:0]  ep;
    sz = q.size();
    chk("R1 count", count, sz);
    chk("R1 empty", empty, sz == 0);
    chk("R1 full", full, sz == 16);
    chk("R9 dreq", dreq, xfer_dir ? ((16 - sz) >= 8) : (sz >= 8));
    chk("R4 ovf_flag", ovf_flag, m_ovf);
    chk("R5 udf_flag", udf_flag, m_udf);
    chk("R6 perr_flag", perr_flag, m_perr);
    if (sz > 0) chk("R2 byte_rdata", byte_rdata, q[0][7:0]);
    if (m_armed && sz >= 1) begin
      ew = {q[0][7:0], m_align};
      ep = {lane_par(q[0], par_mode), opar(m_align)};
      chk("R8 aligned dma_rdata", dma_rdata, ew);
      chk("R8 aligned dma_rpar", dma_rpar, ep);
    end else if (!m_armed && sz >= 2) begin
      ew = {q[1][7:0], q[0][7:0]};
      ep = {lane_par(q[1], par_mode), lane_par(q[0], par_mode)};
      chk("R3 dma_rdata", dma_rdata, ew);
      chk(par_mode ? "R7 dma_rpar" : "R6 dma_rpar", dma_rpar, ep);
    end
  endtask

  task automatic run1();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
    idle();
  endtask

  task automatic wword(input logic [15:0] d, input logic [1:0] p);
    dma_wr = 1; dma_wdata = d; dma_wpar = p; run1();
  endtask

  task automatic spush(input logic [7:0] d);
    sc_push = 1; sc_wdata = d; run1();
  endtask

  task automatic do_flush_clear();
    flush = 1; err_clr = 1; run1();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    par_mode = 0; xfer_dir = 0; align_data = 0; dma_wdata = 0; dma_wpar = 0;
    sc_wdata = 0; host_wdata = 0;
    q.delete(); m_armed = 0; m_ovf = 0; m_udf = 0; m_perr = 0; m_align = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset count", count, 0);
    chk("R1 reset empty", empty, 1);
    chk("R1 reset flags", {ovf_flag, udf_flag, perr_flag}, 0);
    compare_all();

    // R2 word split, low byte first
    wword(16'hA55A, {opar(8'hA5), opar(8'h5A)});
    chk("R2 low byte first", byte_rdata, 8'h5A);
    sc_pop = 1; run1();
    chk("R2 high byte second", byte_rdata, 8'hA5);
    sc_pop = 1; run1();

    // R3 and R13 byte packing through both byte ports
    host_wr = 1; host_wdata = 8'h11; run1();
    spush(8'h22);
    chk("R3 packed word", dma_wdata == 0 ? dma_rdata : dma_rdata, 16'h2211);
    dma_rd = 1; run1();
    chk("R3 word read count", count, 0);
    host_wr = 1; host_wdata = 8'h3C; run1();
    host_rd = 1; run1();
    chk("R13 host pop empties", empty, 1);

    // R12 priority: byte-stream push wins over host push
    sc_push = 1; sc_wdata = 8'h44; host_wr = 1; host_wdata = 8'h55; run1();
    chk("R12 one byte taken", count, 1);
    chk("R12 stream byte kept", byte_rdata, 8'h44);
    flush = 1; dma_wr = 1; dma_wdata = 16'h1234; run1();
    chk("R12 flush wins", count, 0);

    // R4 overflow at exactly 15 bytes
    for (int i = 0; i < 7; i++) wword(16'h0101 * i, {opar(8'(i)), opar(8'(i))});
    spush(8'hEE);
    chk("R4 fifteen stored", count, 15);
    wword(16'hBEEF, 2'b00);
    chk("R4 refused word", count, 15);
    chk("R4 ovf set", ovf_flag, 1);
    spush(8'hEF);
    chk("R1 full", full, 1);
    spush(8'hF0);
    chk("R4 full push refused", count, 16);
    err_clr = 1; run1();
    chk("R11 flags cleared", {ovf_flag, udf_flag, perr_flag}, 0);

    // R10 flush resets state and pointers, then R5 underflow on one byte
    flush = 1; run1();
    chk("R10 flushed", empty, 1);
    spush(8'h61);
    dma_rd = 1; run1();
    chk("R5 refused word read", count, 1);
    chk("R5 udf set", udf_flag, 1);
    chk("R10 pointer at slot zero", byte_rdata, 8'h61);
    do_flush_clear();

    // R8 alignment with a single stored byte
    align_wr = 1; align_data = 8'h77; run1();
    spush(8'h88);
    chk("R8 aligned word", dma_rdata, 16'h8877);
    dma_rd = 1; run1();
    chk("R8 one byte consumed", count, 0);
    chk("R8 no underflow", udf_flag, 0);
    spush(8'h99);
    dma_rd = 1; run1();
    chk("R8 disarmed after use", udf_flag, 1);
    do_flush_clear();
    align_wr = 1; align_data = 8'h12; run1();
    flush = 1; run1();
    spush(8'hAB);
    dma_rd = 1; run1();
    chk("R10 flush disarms", count, 1);
    do_flush_clear();

    // R6 parity check and R7 pass-through
    par_mode = 0;
    wword(16'h0101, 2'b11);
    chk("R6 mismatch flagged", perr_flag, 1);
    chk("R6 generated parity", dma_rpar, 2'b00);
    do_flush_clear();
    par_mode = 1;
    wword(16'h0000, 2'b10);
    chk("R7 no check", perr_flag, 0);
    chk("R7 stored parity", dma_rpar, 2'b10);
    do_flush_clear();

    // R9 threshold in both directions
    par_mode = 0; xfer_dir = 0;
    for (int i = 0; i < 4; i++) wword(16'hC3C3, {opar(8'hC3), opar(8'hC3)});
    chk("R9 eight ready", dreq, 1);
    xfer_dir = 1;
    #1 chk("R9 eight free", dreq, 1);
    spush(8'h01);
    chk("R9 seven free", dreq, 0);
    do_flush_clear();

    // seeded random mix
    void'($urandom(32'h1A2B3C4D));
    for (int n = 0; n < 6000; n++) begin
      dma_wr  = ($urandom_range(0, 99) < 25);
      dma_rd  = ($urandom_range(0, 99) < 22);
      sc_push = ($urandom_range(0, 99) < 30);
      sc_pop  = ($urandom_range(0, 99) < 25);
      host_wr = ($urandom_range(0, 99) < 20);
      host_rd = ($urandom_range(0, 99) < 20);
      flush   = ($urandom_range(0, 99) < 1);
      err_clr = ($urandom_range(0, 99) < 5);
      align_wr = ($urandom_range(0, 99) < 3);
      align_data = 8'($urandom);
      dma_wdata  = 16'($urandom);
      dma_wpar   = 2'($urandom);
      sc_wdata   = 8'($urandom);
      host_wdata = 8'($urandom);
      if ($urandom_range(0, 99) < 2) par_mode = ~par_mode;
      if ($urandom_range(0, 99) < 5) xfer_dir = ~xfer_dir;
      run1();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule